// File: doc/BRIEF.md
# Gated Multiply-Accumulate Accumulator with Output Hold

This block gathers the signed products of a FIR filter's multiplier stage into a running sum. A single accumulate-enable line controls it. While the line is high, each new product is added to the running sum and the published result stays frozen. When the line goes low, the feedback into the adder is forced to zero, so the running sum restarts from the product of that cycle. In the same cycle the total completed so far is copied into the output register.

The block has one accumulation lane per filter. All lanes share the enable line and are otherwise fully independent. With two lanes it serves a dual-filter arrangement. A host that decimates by N reads the result once every N clocks. It drives the enable low once per block and high for the N−1 cycles between, so each published value folds N times as many products. Eight multipliers then give up to 8N taps per filter. The 20-bit signed products are sign-extended into a 32-bit signed sum, which leaves headroom for 8N full-scale products with N up to 16.

Top module: `gated_mac_acc`

## Requirements
- R1: While `rst_ni` is low, every lane's result and running sum are zero. The first low-enable cycle after reset therefore publishes 0.
- R2: In a cycle with `acc_en_i` low, each lane's running sum is reloaded with the sign-extended product of that cycle alone. Nothing from earlier cycles is carried over.
- R3: In a cycle with `acc_en_i` high, each lane's running sum becomes its previous value plus the sign-extended product of that cycle.
- R4: In a cycle with `acc_en_i` high, `result_o` keeps its value at the next clock edge.
- R5: In a cycle with `acc_en_i` low, each lane's `result_o` takes, at that clock edge, the running sum held just before the edge. That value is the total of the block that is ending.
- R6: Lane k uses bits [k*PROD_W +: PROD_W] of `prod_i` and drives bits [k*ACC_W +: ACC_W] of `result_o`. Lanes share the enable and never affect each other's values.
- R7: Products are two's-complement signed, and the sum is sign-extended and signed. Negative products reduce the total.
- R8: A block of 128 full-scale products (−2^19 each, or 2^19−1 each) produces the exact total with no wrap.
- R9: Block length is set only by the spacing of low-enable cycles. Any run of high cycles from 0 upward gives the sum of that block's products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_en_i | input | 1 | High: accumulate and hold the output. Low: restart the sum and publish the total |
| prod_i | input | NUM_LANES*PROD_W | Packed signed products, lane 0 in the low bits |
| result_o | output | NUM_LANES*ACC_W | Packed signed published totals, lane 0 in the low bits |

## Verification
The bench runs back-to-back low-enable cycles, where each block holds one product. A design that failed to zero the feedback would carry the old sum into the next block. A design that published on the wrong cycle would show the product alone or lose a block. Full-scale runs of 128 negative and positive products expose a design with a narrow sum or missing sign extension, which would wrap or treat negative products as large positive ones. Opposite-sign patterns on the two lanes catch swapped or crossed lane slices. Blocks of random length, mixed with mid-run resets, catch an output register that updates while accumulation is running.

// File: rtl/gated_mac_acc_pkg.sv
package gated_mac_acc_pkg;
    localparam int unsigned DEF_PROD_W = 20;
    localparam int unsigned DEF_ACC_W  = 32;
    localparam int unsigned DEF_LANES  = 2;

    // Decoded meaning of the shared enable line.
    typedef enum logic {
        MODE_RESTART = 1'b0,
        MODE_FOLD    = 1'b1
    } acc_mode_e;

    function automatic acc_mode_e decode_mode(input logic en);
        return en ? MODE_FOLD : MODE_RESTART;
    endfunction
endpackage

// File: rtl/gated_mac_fb_gate.sv
module gated_mac_fb_gate
    import gated_mac_acc_pkg::*;
#(
    parameter int unsigned ACC_W = DEF_ACC_W
) (
    input  acc_mode_e         mode_i,
    input  logic [ACC_W-1:0]  sum_i,
    output logic [ACC_W-1:0]  fb_o
);
    // Forces the feedback to zero on a restart cycle.
    always_comb begin
        fb_o = '0;
        if (mode_i == MODE_FOLD) begin
            fb_o = sum_i;
        end
    end
endmodule

// File: rtl/gated_mac_lane.sv
module gated_mac_lane
    import gated_mac_acc_pkg::*;
#(
    parameter int unsigned PROD_W = DEF_PROD_W,
    parameter int unsigned ACC_W  = DEF_ACC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  acc_mode_e         mode_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic [ACC_W-1:0]  sum_o,
    output logic [ACC_W-1:0]  result_o
);
    localparam int unsigned EXT_W = ACC_W - PROD_W;

    typedef struct packed {
        logic [ACC_W-1:0] sum;
        logic [ACC_W-1:0] pub;
    } lane_state_t;

    lane_state_t      st_d, st_q;
    logic [ACC_W-1:0] fb;
    logic [ACC_W-1:0] prod_ext;

    gated_mac_fb_gate #(.ACC_W(ACC_W)) fb_gate_i (
        .mode_i (mode_i),
        .sum_i  (st_q.sum),
        .fb_o   (fb)
    );

    assign prod_ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};

    always_comb begin
        st_d     = st_q;
        st_d.sum = prod_ext + fb;
        if (mode_i == MODE_RESTART) begin
            st_d.pub = st_q.sum;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o    = st_q.sum;
    assign result_o = st_q.pub;
endmodule

// File: rtl/gated_mac_acc.sv
module gated_mac_acc
    import gated_mac_acc_pkg::*;
#(
    parameter int unsigned NUM_LANES = DEF_LANES,
    parameter int unsigned PROD_W    = DEF_PROD_W,
    parameter int unsigned ACC_W     = DEF_ACC_W
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          acc_en_i,
    input  logic [NUM_LANES*PROD_W-1:0]   prod_i,
    output logic [NUM_LANES*ACC_W-1:0]    result_o
);
    localparam int unsigned SUM_BUS_W = NUM_LANES * ACC_W;

    acc_mode_e              mode;
    logic [SUM_BUS_W-1:0]   sum_bus;

    assign mode = decode_mode(acc_en_i);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        gated_mac_lane #(.PROD_W(PROD_W), .ACC_W(ACC_W)) lane_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .mode_i   (mode),
            .prod_i   (prod_i[k*PROD_W +: PROD_W]),
            .sum_o    (sum_bus[k*ACC_W +: ACC_W]),
            .result_o (result_o[k*ACC_W +: ACC_W])
        );
    end
endmodule

// File: rtl/gated_mac_acc_chk.sv
module gated_mac_acc_chk #(
    parameter int unsigned NUM_LANES = 2,
    parameter int unsigned PROD_W    = 20,
    parameter int unsigned ACC_W     = 32
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        acc_en_i,
    input logic [NUM_LANES*PROD_W-1:0] prod_i,
    input logic [NUM_LANES*ACC_W-1:0]  result_o,
    input logic [NUM_LANES*ACC_W-1:0]  sum_bus
);
    a_r1_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |-> (result_o == '0 && sum_bus == '0));

    a_r4_hold_while_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_en_i |=> $stable(result_o));

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_chk
        a_r5_publish_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !acc_en_i |=> result_o[k*ACC_W +: ACC_W] == $past(sum_bus[k*ACC_W +: ACC_W]));

        a_r2_restart_from_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !acc_en_i |=> $signed(sum_bus[k*ACC_W +: ACC_W])
                == ACC_W'($signed($past(prod_i[k*PROD_W +: PROD_W]))));

        a_r3_fold_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
            acc_en_i |=> sum_bus[k*ACC_W +: ACC_W]
                == ACC_W'($past(sum_bus[k*ACC_W +: ACC_W])
                    + ACC_W'($signed($past(prod_i[k*PROD_W +: PROD_W])))));
    end
endmodule

bind gated_mac_acc gated_mac_acc_chk #(
    .NUM_LANES (NUM_LANES),
    .PROD_W    (PROD_W),
    .ACC_W     (ACC_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_en_i (acc_en_i),
    .prod_i   (prod_i),
    .result_o (result_o),
    .sum_bus  (sum_bus)
);

// File: tb/gated_mac_acc_tb_top.sv
module gated_mac_acc_tb_top;
    localparam int unsigned LANES = 2;
    localparam int unsigned PW    = 20;
    localparam int unsigned AW    = 32;

    logic                 clk_i = 1'b0;
    logic                 rst_ni;
    logic                 acc_en_i;
    logic [LANES*PW-1:0]  prod_i;
    logic [LANES*AW-1:0]  result_o;

    int    total = 0;
    int    bad   = 0;
    bit    finished = 1'b0;
    longint exp_sum [LANES];
    longint exp_pub [LANES];

    always #5 clk_i = ~clk_i;

    gated_mac_acc #(.NUM_LANES(LANES), .PROD_W(PW), .ACC_W(AW)) dut_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .acc_en_i (acc_en_i),
        .prod_i   (prod_i),
        .result_o (result_o)
    );

    task automatic check_outputs(input string tag);
        for (int l = 0; l < LANES; l++) begin
            longint got;
            got = longint'($signed(result_o[l*AW +: AW]));
            total++;
            if (got != exp_pub[l]) begin
                bad++;
                $display("FAIL %s lane%0d: got %0d expected %0d", tag, l, got, exp_pub[l]);
            end
        end
    endtask

    // One clock: drive at negedge, model at posedge, check at next negedge.
    task automatic step(input logic en, input int a, input int b, input string tag);
        logic signed [PW-1:0] pa, pb;
        pa = PW'(a);
        pb = PW'(b);
        acc_en_i = en;
        prod_i   = {pb, pa};
        @(posedge clk_i);
        for (int l = 0; l < LANES; l++) begin
            longint p;
            p = (l == 0) ? longint'(pa) : longint'(pb);
            if (!en) exp_pub[l] = exp_sum[l];
            exp_sum[l] = p + (en ? exp_sum[l] : 0);
        end
        @(negedge clk_i);
        check_outputs(tag);
    endtask

    task automatic apply_reset();
        rst_ni   = 1'b0;
        acc_en_i = 1'b1;
        prod_i   = '0;
        for (int l = 0; l < LANES; l++) begin
            exp_sum[l] = 0;
            exp_pub[l] = 0;
        end
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic t_reset();
        step(1'b1, 77, -5, "R4");
        apply_reset();
        check_outputs("R1");
        step(1'b0, 3, 4, "R1");   // publishes zero from cleared sum
        step(1'b0, 9, 9, "R1");   // publishes 3 / 4
    endtask

    task automatic t_restart();
        step(1'b0, 100, 200, "R2");
        step(1'b0, -7, 11, "R2");
        step(1'b0, 0, 0, "R5");
    endtask

    task automatic t_fold_hold();
        step(1'b0, 10, 20, "R5");
        step(1'b1, 1, 2, "R4");
        step(1'b1, 3, 4, "R4");
        step(1'b1, 5, 6, "R3");
        step(1'b0, 0, 0, "R3");   // publishes 19 / 32
    endtask

    task automatic t_lanes();
        step(1'b0, 1000, -1000, "R6");
        step(1'b1, 2500, -2500, "R6");
        step(1'b0, 0, 77, "R6");
        step(1'b0, 0, 0, "R6");
    endtask

    task automatic t_negative();
        step(1'b0, -1, -524288, "R7");
        step(1'b1, -1, 1, "R7");
        step(1'b1, -300, 524287, "R7");
        step(1'b0, 0, 0, "R7");
    endtask

    task automatic t_full_scale();
        step(1'b0, -524288, 524287, "R8");
        for (int i = 1; i < 128; i++) step(1'b1, -524288, 524287, "R8");
        step(1'b0, 0, 0, "R8");   // publishes -2^26 / 128*(2^19-1)
    endtask

    task automatic t_decim();
        for (int blk = 0; blk < 40; blk++) begin
            int n;
            n = int'($urandom_range(16, 1));
            step(1'b0, int'($urandom_range(1048575, 0)) - 524288,
                       int'($urandom_range(1048575, 0)) - 524288, "R9");
            for (int i = 1; i < n; i++)
                step(1'b1, int'($urandom_range(1048575, 0)) - 524288,
                           int'($urandom_range(1048575, 0)) - 524288, "R9");
        end
        step(1'b0, 0, 0, "R9");
        apply_reset();
        check_outputs("R1");
        step(1'b0, 5, 5, "R1");
    endtask

    initial begin
        apply_reset();
        @(negedge clk_i);
        t_reset();
        t_restart();
        t_fold_hold();
        t_lanes();
        t_negative();
        t_full_scale();
        t_decim();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule